// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a management-bus master for talking to an external Ethernet PHY. Software builds a complete 32-bit management frame in one word: start code, opcode, PHY address, register address, turnaround code and 16 data bits. It then writes that word to the block. The block sends 32 preamble ones, then shifts the word out MSB first on the MDIO line. It generates the management clock MDC from the system clock.

For a read, the block drives only the start, opcode and address bits. It releases MDIO from the turnaround onward. It samples the 16 bits returned by the PHY on the rising edges of MDC and puts them into the low half of the command word. The idle output stays low for the whole frame, so software can poll it.

The MDC divisor comes from a 3-bit select field. The integrator picks the select code from the system clock rate so that MDC stays within the PHY's limit:

| System clock | Divisor |
|---|---|
| up to 20 MHz | 8 |
| up to 40 MHz | 16 |
| up to 80 MHz | 32 |
| up to 120 MHz | 48 |
| up to 160 MHz | 64 |
| above 160 MHz | 96 |

A management-port enable input gates the start of new frames.

Top module: `mgmt_frame_ctrl`

## Requirements
- R1: After reset, idle_o is 1, mdc_o is 0, mdio_oe_o is 0 and cmd_rdata_o is 0.
- R2: A command write while idle with port_en_i high loads cmd_wdata_i and starts a frame. idle_o is low for exactly 64 x divisor system cycles after the loading edge.
- R3: The frame on the line is 32 ones, followed by command bits 31 down to 0, MSB first. The field positions are: bits 31:30 start (01), bits 29:28 opcode, bits 27:23 PHY address, bits 22:18 register address, bits 17:16 turnaround, bits 15:0 data. Any opcode other than 10 is sent as a write, with all 64 bits driven.
- R4: With opcode 10 (read), MDIO is driven for the preamble and command bits 31:18, and released (mdio_oe_o low) for the remaining 18 bit times.
- R5: On a read, the 16 bits sampled on the rising edges of MDC during the last 16 bit times replace cmd_rdata_o[15:0], first bit in the MSB. Bits 31:16 are unchanged. After a write frame, cmd_rdata_o equals the written word.
- R6: Divisor by div_sel_i: 0 gives 8, 1 gives 16, 2 gives 32, 3 gives 64, 4 gives 48, 5 gives 96, and 6 or 7 give 64. The value is taken when the frame starts.
- R7: While idle, mdc_o and mdio_oe_o are 0. MDC is low for the first half and high for the second half of each bit time. Data changes at the start of a bit, and a frame ends on a falling MDC edge.
- R8: A command write while a frame is in progress is ignored. The current frame, its bits and its result are unaffected, and no second frame follows.
- R9: A command write while port_en_i is low is ignored. idle_o stays 1 and cmd_rdata_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| port_en_i | input | 1 | Management port enable |
| div_sel_i | input | 3 | MDC divisor select code |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 32 | Command word to load |
| cmd_rdata_o | output | 32 | Command word with read data merged |
| idle_o | output | 1 | High when no frame is in progress |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
The assertions check the following on every cycle:
- the bus is quiet while idle;
- a frame only starts from a write with the port enabled;
- the bit index only holds or steps by one;
- the upper command fields cannot change during a frame;
- a frame always ends on a falling MDC edge.

Only the scenarios run by the bench can show the rest. The bench captures the 64 line bits on each rising MDC edge and compares them with the expected frame. It reads back the received PHY data, and measures the busy time for every divisor code. It also checks that writes during a frame or with the port disabled leave no trace.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int unsigned CMD_W      = 32;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned PRE_BITS   = 32;
  localparam int unsigned FRAME_BITS = PRE_BITS + CMD_W;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned HC_W       = 6;
  // bit index where a read releases the line (turnaround start)
  localparam int unsigned RD_REL_IDX = FRAME_BITS - DATA_W - 2;
  localparam int unsigned RD_DAT_IDX = FRAME_BITS - DATA_W;
  localparam logic [1:0]  OP_RD      = 2'b10;

  typedef enum logic [SEL_W-1:0] {
    DIV8  = 3'd0,
    DIV16 = 3'd1,
    DIV32 = 3'd2,
    DIV64 = 3'd3,
    DIV48 = 3'd4,
    DIV96 = 3'd5
  } div_sel_e;

  function automatic logic [HC_W-1:0] half_period(input logic [SEL_W-1:0] sel);
    case (sel)
      DIV8:    half_period = HC_W'(4);
      DIV16:   half_period = HC_W'(8);
      DIV32:   half_period = HC_W'(16);
      DIV48:   half_period = HC_W'(24);
      DIV96:   half_period = HC_W'(48);
      default: half_period = HC_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/mfc_clk_gen.sv
module mfc_clk_gen
  import mfc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [SEL_W-1:0] sel_q;
  logic [HC_W-1:0]  hc_q;
  logic [HC_W-1:0]  half;
  logic             mdc_q;
  logic             wrap;

  assign half = half_period(sel_q);
  assign wrap = (hc_q == half - HC_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      hc_q  <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      sel_q <= div_sel_i;   // divisor frozen for the frame
      hc_q  <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      hc_q  <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      hc_q  <= hc_q + HC_W'(1);
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = run_i & wrap & ~mdc_q;
  assign fall_o = run_i & wrap &  mdc_q;

  // R7
  frame_ends_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_i) |-> (!mdc_q && $past(mdc_q)));
endmodule

// File: rtl/mfc_frame_seq.sv
module mfc_frame_seq
  import mfc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             port_en_i,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             mdio_i,
  output logic             busy_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             mdio_o,
  output logic             mdio_oe_o
);
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [CMD_W-1:0] cmd_q;
  logic             start;
  logic             is_rd;
  logic             tx_bit;

  assign start = cmd_we_i & ~busy_q & port_en_i;
  assign is_rd = (cmd_q[29:28] == OP_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cmd_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      cmd_q  <= cmd_wdata_i;
    end else if (busy_q) begin
      if (rise_i && is_rd && idx_q >= IDX_W'(RD_DAT_IDX))
        cmd_q[DATA_W-1:0] <= {cmd_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (idx_q == IDX_W'(FRAME_BITS - 1)) busy_q <= 1'b0;
        else                                 idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end

  // preamble is all ones; command bit 31 goes first
  assign tx_bit    = idx_q[IDX_W-1] ? cmd_q[~idx_q[IDX_W-2:0]] : 1'b1;
  assign mdio_oe_o = busy_q & (~is_rd | (idx_q < IDX_W'(RD_REL_IDX)));
  assign mdio_o    = mdio_oe_o & tx_bit;
  assign busy_o    = busy_q;
  assign cmd_o     = cmd_q;

  // R2
  start_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(cmd_we_i && port_en_i));
  // R2
  bit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> (idx_q == $past(idx_q) || idx_q == $past(idx_q) + IDX_W'(1)));
  // R8
  busy_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cmd_we_i) |=> $stable(cmd_q[CMD_W-1:DATA_W]));
  // R9
  disabled_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && cmd_we_i && !port_en_i) |=> (!busy_q && $stable(cmd_q)));
endmodule

// File: rtl/mgmt_frame_ctrl.sv
module mgmt_frame_ctrl
  import mfc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             port_en_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  output logic [CMD_W-1:0] cmd_rdata_o,
  output logic             idle_o,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  input  logic             mdio_i
);
  logic busy, rise, fall;

  mfc_clk_gen u_clk_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy),
    .div_sel_i (div_sel_i),
    .mdc_o     (mdc_o),
    .rise_o    (rise),
    .fall_o    (fall)
  );

  mfc_frame_seq u_frame_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .port_en_i   (port_en_i),
    .cmd_we_i    (cmd_we_i),
    .cmd_wdata_i (cmd_wdata_i),
    .rise_i      (rise),
    .fall_i      (fall),
    .mdio_i      (mdio_i),
    .busy_o      (busy),
    .cmd_o       (cmd_rdata_o),
    .mdio_o      (mdio_o),
    .mdio_oe_o   (mdio_oe_o)
  );

  assign idle_o = ~busy;

  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (!mdc_o && !mdio_oe_o));
endmodule

// File: tb/mgmt_frame_ctrl_tb_top.sv
`timescale 1ns/1ps
module mgmt_frame_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_en = 1'b1;
  logic [2:0]  div_sel = 3'd0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        idle, mdc, mdio_o, mdio_oe;
  logic        phy_drv = 1'b1;
  logic        line;

  assign line = mdio_oe ? mdio_o : phy_drv;

  mgmt_frame_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .div_sel_i(div_sel),
    .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata), .cmd_rdata_o(cmd_rdata),
    .idle_o(idle), .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe),
    .mdio_i(line)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [63:0] bits;
    logic [31:0] rdata;
    int          cycles;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  logic [15:0] phy_resp = '0;
  logic [63:0] cap_bits = '0;
  int          rises = 0;
  int          busy_cnt = 0;
  bit          in_frame = 0;
  bit          done = 0;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // PHY model and line capture
  always @(posedge mdc) begin
    cap_bits = {cap_bits[62:0], line};
    rises++;
  end
  always @(negedge mdc) begin
    if (rises >= 48 && rises <= 63) phy_drv = phy_resp[63-rises];
    else                            phy_drv = 1'b1;
  end

  // monitor: pop and compare at the end of every frame
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !idle) begin
        busy_cnt++;
        in_frame = 1;
      end else if (in_frame) begin
        exp_t e;
        in_frame = 0;
        if (sb_q.size() == 0) begin
          check(0, "R8 unexpected frame", 64'(busy_cnt), 64'(0));
        end else begin
          e = sb_q.pop_front();
          // R3 R4 frame bits on the line
          check(cap_bits == e.bits, {e.tag, " R3/R4 line bits"}, cap_bits, e.bits);
          // R5 readback
          check(cmd_rdata == e.rdata, {e.tag, " R5 readback"}, 64'(cmd_rdata), 64'(e.rdata));
          // R2 R6 busy time
          check(busy_cnt == e.cycles, {e.tag, " R2/R6 busy cycles"}, 64'(busy_cnt), 64'(e.cycles));
        end
        busy_cnt = 0;
        rises = 0;
        cap_bits = '0;
      end
    end
  end

  function automatic int div_of(logic [2:0] s);
    case (s)
      3'd0: return 8;
      3'd1: return 16;
      3'd2: return 32;
      3'd4: return 48;
      3'd5: return 96;
      default: return 64;
    endcase
  endfunction

  task automatic write_cmd(logic [31:0] w);
    @(negedge clk);
    cmd_wdata = w;
    cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic run_frame(logic [31:0] w, logic [2:0] sel, logic [15:0] resp, string tag);
    exp_t e;
    div_sel = sel;
    phy_resp = resp;
    if (w[29:28] == 2'b10) begin
      e.bits  = {32'hFFFF_FFFF, w[31:18], 2'b11, resp};
      e.rdata = {w[31:16], resp};
    end else begin
      e.bits  = {32'hFFFF_FFFF, w};
      e.rdata = w;
    end
    e.cycles = 64 * div_of(sel);
    e.tag = tag;
    sb_q.push_back(e);
    write_cmd(w);
    wait (idle);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(logic [1:0] op, logic [4:0] pa, logic [4:0] ra, logic [15:0] d);
    return {2'b01, op, pa, ra, 2'b10, d};
  endfunction

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(idle == 1'b1,  "R1 idle",  64'(idle), 64'(1));
    check(mdc == 1'b0,   "R1 mdc",   64'(mdc), 64'(0));
    check(mdio_oe == 1'b0, "R1 oe",  64'(mdio_oe), 64'(0));
    check(cmd_rdata == 32'h0, "R1 rdata", 64'(cmd_rdata), 64'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_frame(mk(2'b01, 5'h03, 5'h11, 16'hA5C3), 3'd0, 16'h0000, "R3 write div8");
    run_frame(mk(2'b10, 5'h1F, 5'h01, 16'h0000), 3'd0, 16'h8D3B, "R4 read div8");
    run_frame(mk(2'b10, 5'h00, 5'h1E, 16'hFFFF), 3'd1, 16'h0001, "R5 read div16");
    run_frame(mk(2'b01, 5'h15, 5'h0A, 16'h0F0F), 3'd2, 16'h0000, "R6 write div32");
    run_frame(mk(2'b01, 5'h0A, 5'h15, 16'hF00F), 3'd3, 16'h0000, "R6 write div64");
    run_frame(mk(2'b10, 5'h11, 5'h02, 16'h1234), 3'd4, 16'hFFFE, "R6 read div48");
    run_frame(mk(2'b01, 5'h01, 5'h1F, 16'h5AA5), 3'd5, 16'h0000, "R6 write div96");
    run_frame(mk(2'b11, 5'h02, 5'h04, 16'h7777), 3'd6, 16'h0000, "R6 code6 div64");
    run_frame(mk(2'b00, 5'h04, 5'h08, 16'h1111), 3'd7, 16'h0000, "R3 op00 code7");

    // R8: second write during a read frame is ignored
    begin
      exp_t e;
      logic [31:0] w;
      w = mk(2'b10, 5'h09, 5'h0C, 16'h0000);
      div_sel = 3'd0;
      phy_resp = 16'hC0DE;
      e.bits = {32'hFFFF_FFFF, w[31:18], 2'b11, 16'hC0DE};
      e.rdata = {w[31:16], 16'hC0DE};
      e.cycles = 512;
      e.tag = "R8 busy write";
      sb_q.push_back(e);
      write_cmd(w);
      repeat (40) @(negedge clk);
      write_cmd(mk(2'b01, 5'h1A, 5'h1B, 16'hDEAD));
      wait (idle);
      repeat (30) @(negedge clk);
      check(idle == 1'b1, "R8 no second frame", 64'(idle), 64'(1));
      check(sb_q.size() == 0, "R8 queue drained", 64'(sb_q.size()), 64'(0));
    end

    // R9: write with port disabled is ignored
    held = cmd_rdata;
    port_en = 1'b0;
    write_cmd(mk(2'b01, 5'h05, 5'h06, 16'hBEEF));
    repeat (5) @(negedge clk);
    check(idle == 1'b1, "R9 stays idle", 64'(idle), 64'(1));
    check(cmd_rdata == held, "R9 rdata kept", 64'(cmd_rdata), 64'(held));
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R7 quiet when idle", 64'({mdc, mdio_oe}), 64'(0));
    port_en = 1'b1;
    run_frame(mk(2'b01, 5'h05, 5'h06, 16'hBEEF), 3'd1, 16'h0000, "R9 enabled again");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule